// File: doc/BRIEF.md
# Sixteen-bit ALU with NZCV flags

This block is the arithmetic and logic unit of a small 16-bit processor datapath. Each cycle it takes a 4-bit operation code and two operands that the surrounding datapath has already prepared. The second operand is either a register value or an extended immediate. From these it produces a result and a write strobe for the destination register, both in the same cycle. It also keeps its own four condition flags: negative, zero, carry and overflow. These flags follow the conventions of classic 8-bit microprocessors, and carry means "borrow" after a subtraction.

The flags live in a register inside the block. A flag-updating operation presented in one cycle becomes visible on `flags_o` after the next rising clock edge. The stored carry feeds back into add-with-carry and subtract-with-carry, so multi-word arithmetic can be chained one instruction after another. Compare and test only update the flags. The shifts use the first operand alone and move it by exactly one bit. The spare operation codes do nothing.

The adder can be built as a behavioural sum or as an explicit ripple chain, chosen by parameter. Both give the same results.

Top module: `flag_alu`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `flags_o` is 0000.
- R2: Operation 1 (add) gives `res_o` = a+b mod 2^16 with `wr_en_o` high. C is the carry out of bit 15, and V is set on signed overflow.
- R3: Operation 2 (subtract) gives `res_o` = a-b mod 2^16 with `wr_en_o` high. C is set when a < b unsigned (a borrow), and V is set on signed overflow.
- R4: Operation 3 (add-with-carry) adds the stored C to a+b. Operation 4 (subtract-with-carry) subtracts the stored C in addition to b, and its C reports the borrow of the whole a-b-C. V follows the same signed-overflow rule as R2 and R3.
- R5: Operation 5 (compare) updates the flags exactly as subtract does, and operation 13 (test) updates them from a AND b. Both hold `wr_en_o` low, while `res_o` still shows the difference or the AND.
- R6: Operations 6 (OR), 7 (AND) and 8 (XOR) write the bitwise result. They clear V and keep C unchanged.
- R7: Operation 9 (shift left) writes a<<1 with bit 0 equal to 0 and sets C to a[15]. All shifts ignore `b_i`.
- R8: Operation 10 (logical shift right) writes a>>1 with bit 15 equal to 0. Operation 12 (arithmetic shift right) writes a>>1 with bit 15 copied from a[15]. In both, C takes a[0].
- R9: After any shift, V equals N XOR C of the new flags.
- R10: After every flag-updating operation (1 to 10, 12, 13), N equals bit 15 of the computed value and Z is set exactly when that value is zero.
- R11: Operations 0, 11, 14 and 15 drive `res_o` to 0 and `wr_en_o` low, and they leave all four flags unchanged.
- R12: `flags_o` is packed as bit 3 N, bit 2 Z, bit 1 C, bit 0 V. It changes only at a rising clock edge, while `res_o` and `wr_en_o` follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flag register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| op_i | input | 4 | Operation code |
| a_i | input | 16 | First operand; the only operand used by shifts |
| b_i | input | 16 | Second operand (register or extended immediate) |
| res_o | output | 16 | Computed value, combinational |
| wr_en_o | output | 1 | Destination register write strobe, combinational |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The flag register is the only state in the block. A wrong carry or overflow bit shows up on `flags_o` one edge after the operation that produced it. A wrong stored carry also corrupts `res_o` of the very next add-with-carry or subtract-with-carry in the same cycle it is presented. The bench therefore tracks its own copy of the flags. It checks `res_o` and `wr_en_o` mid-cycle and `flags_o` just after each edge, so any divergence is caught within one operation. Long random runs chain carry-consuming operations behind every kind of flag producer. Directed cases cover wrap-around, overflow at 0x7FFF/0x8000, borrow with a stored carry, and flag holding across spare codes and logic operations.

// File: rtl/alu17_pkg.sv
package alu17_pkg;

   typedef enum logic [3:0] {
      OP_NOP0  = 4'd0,
      OP_ADD   = 4'd1,
      OP_SUB   = 4'd2,
      OP_ADDC  = 4'd3,
      OP_SUBC  = 4'd4,
      OP_CMP   = 4'd5,
      OP_OR    = 4'd6,
      OP_AND   = 4'd7,
      OP_XOR   = 4'd8,
      OP_SHL   = 4'd9,
      OP_LSR   = 4'd10,
      OP_NOP11 = 4'd11,
      OP_ASR   = 4'd12,
      OP_TST   = 4'd13,
      OP_NOP14 = 4'd14,
      OP_NOP15 = 4'd15
   } alu_op_e;

   typedef enum logic [1:0] {
      SH_LEFT = 2'd0,
      SH_LOG  = 2'd1,
      SH_ARI  = 2'd2,
      SH_NONE = 2'd3
   } shift_mode_e;

   typedef enum logic [1:0] {
      LG_OR   = 2'd0,
      LG_AND  = 2'd1,
      LG_XOR  = 2'd2,
      LG_ZERO = 2'd3
   } logic_sel_e;

   localparam int FLAG_N = 3;
   localparam int FLAG_Z = 2;
   localparam int FLAG_C = 1;
   localparam int FLAG_V = 0;
   localparam int NFLAGS = 4;

endpackage

// File: rtl/alu17_addsub.sv
module alu17_addsub #(
   parameter int WIDTH  = 16,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   input  logic             use_c_i,
   input  logic             c_flag_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             c_o,
   output logic             v_o
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   logic             cin;
   logic             cout;

   // subtraction as a + ~b + 1, an extra borrow removes the +1
   assign b_eff = sub_i ? ~b_i : b_i;
   assign cin   = sub_i ? ~(use_c_i & c_flag_i) : (use_c_i & c_flag_i);

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_o[i]  = a_i[i] ^ b_eff[i] ^ cy[i];
            assign cy[i+1]   = (a_i[i] & b_eff[i]) | (cy[i] & (a_i[i] ^ b_eff[i]));
         end
         assign cout = cy[WIDTH];
      end else begin : g_behav
         logic [WIDTH:0] wide;
         assign wide  = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
         assign sum_o = wide[WIDTH-1:0];
         assign cout  = wide[WIDTH];
      end
   endgenerate

   assign c_o = sub_i ? ~cout : cout;
   assign v_o = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);

endmodule

// File: rtl/alu17_shift.sv
module alu17_shift
   import alu17_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_i,
   input  shift_mode_e      mode_i,
   output logic [WIDTH-1:0] res_o,
   output logic             c_o
);
   localparam int MSB = WIDTH - 1;

   always_comb begin
      unique case (mode_i)
         SH_LEFT: begin
            res_o = {a_i[MSB-1:0], 1'b0};
            c_o   = a_i[MSB];
         end
         SH_LOG: begin
            res_o = {1'b0, a_i[MSB:1]};
            c_o   = a_i[0];
         end
         SH_ARI: begin
            res_o = {a_i[MSB], a_i[MSB:1]};
            c_o   = a_i[0];
         end
         default: begin
            res_o = '0;
            c_o   = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/alu17_logic.sv
module alu17_logic
   import alu17_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic_sel_e       sel_i,
   output logic [WIDTH-1:0] res_o
);
   always_comb begin
      unique case (sel_i)
         LG_OR:   res_o = a_i | b_i;
         LG_AND:  res_o = a_i & b_i;
         LG_XOR:  res_o = a_i ^ b_i;
         default: res_o = '0;
      endcase
   end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
   import alu17_pkg::*;
#(
   parameter int WIDTH  = 16,
   parameter bit RIPPLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] res_o,
   output logic             wr_en_o,
   output logic [3:0]       flags_o
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 4) begin : g_width_chk
         $error("flag_alu: WIDTH must be at least 4");
      end
   endgenerate

   alu_op_e            op;
   logic [NFLAGS-1:0]  flags_q;
   logic [NFLAGS-1:0]  flags_d;

   logic               as_sub;
   logic               as_use_c;
   logic [WIDTH-1:0]   as_sum;
   logic               as_c;
   logic               as_v;

   shift_mode_e        sh_mode;
   logic [WIDTH-1:0]   sh_res;
   logic               sh_c;

   logic_sel_e         lg_sel;
   logic [WIDTH-1:0]   lg_res;

   logic [WIDTH-1:0]   res_raw;
   logic               wr_en;
   logic               upd;
   logic               nx_c;
   logic               nx_v;
   logic               nx_n;
   logic               nx_z;

   assign op       = alu_op_e'(op_i);
   assign as_sub   = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
   assign as_use_c = (op == OP_ADDC) || (op == OP_SUBC);

   always_comb begin
      unique case (op)
         OP_SHL:  sh_mode = SH_LEFT;
         OP_LSR:  sh_mode = SH_LOG;
         OP_ASR:  sh_mode = SH_ARI;
         default: sh_mode = SH_NONE;
      endcase
      unique case (op)
         OP_OR:          lg_sel = LG_OR;
         OP_AND, OP_TST: lg_sel = LG_AND;
         OP_XOR:         lg_sel = LG_XOR;
         default:        lg_sel = LG_ZERO;
      endcase
   end

   alu17_addsub #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_addsub (
      .a_i      (a_i),
      .b_i      (b_i),
      .sub_i    (as_sub),
      .use_c_i  (as_use_c),
      .c_flag_i (flags_q[FLAG_C]),
      .sum_o    (as_sum),
      .c_o      (as_c),
      .v_o      (as_v)
   );

   alu17_shift #(.WIDTH(WIDTH)) u_shift (
      .a_i    (a_i),
      .mode_i (sh_mode),
      .res_o  (sh_res),
      .c_o    (sh_c)
   );

   alu17_logic #(.WIDTH(WIDTH)) u_logic (
      .a_i   (a_i),
      .b_i   (b_i),
      .sel_i (lg_sel),
      .res_o (lg_res)
   );

   always_comb begin
      res_raw = '0;
      wr_en   = 1'b0;
      upd     = 1'b0;
      nx_c    = flags_q[FLAG_C];
      nx_v    = flags_q[FLAG_V];
      unique case (op)
         OP_ADD, OP_SUB, OP_ADDC, OP_SUBC, OP_CMP: begin
            res_raw = as_sum;
            wr_en   = (op != OP_CMP);
            upd     = 1'b1;
            nx_c    = as_c;
            nx_v    = as_v;
         end
         OP_OR, OP_AND, OP_XOR, OP_TST: begin
            res_raw = lg_res;
            wr_en   = (op != OP_TST);
            upd     = 1'b1;
            nx_v    = 1'b0;
         end
         OP_SHL, OP_LSR, OP_ASR: begin
            res_raw = sh_res;
            wr_en   = 1'b1;
            upd     = 1'b1;
            nx_c    = sh_c;
            nx_v    = sh_res[MSB] ^ sh_c;
         end
         default: ;
      endcase
   end

   assign nx_n    = res_raw[MSB];
   assign nx_z    = (res_raw == '0);
   assign flags_d = upd ? {nx_n, nx_z, nx_c, nx_v} : flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_d;
   end

   assign res_o   = res_raw;
   assign wr_en_o = wr_en;
   assign flags_o = flags_q;

   AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd0 || op_i == 4'd11 || op_i == 4'd14 || op_i == 4'd15) |=> $stable(flags_o)); // R11

   AST_FLAGONLY_NOWR: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd5 || op_i == 4'd13) |-> !wr_en_o); // R5

   AST_LOGIC_C_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd6 || op_i == 4'd7 || op_i == 4'd8) |=>
      (flags_o[FLAG_C] == $past(flags_o[FLAG_C])) && !flags_o[FLAG_V]); // R6

   AST_Z_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> (flags_o[FLAG_Z] == ($past(res_raw) == '0))); // R10

   AST_SHL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd9) |=> (flags_o[FLAG_C] == $past(a_i[MSB]))); // R7

   AST_SHIFT_V: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd9 || op_i == 4'd10 || op_i == 4'd12) |=>
      (flags_o[FLAG_V] == (flags_o[FLAG_N] ^ flags_o[FLAG_C]))); // R9

endmodule

// File: tb/sim_flag_alu.sv
module sim_flag_alu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op = 4'd0;
   logic [15:0] a = '0;
   logic [15:0] b = '0;
   logic [15:0] res;
   logic        wr;
   logic [3:0]  flags;

   int n_chk  = 0;
   int n_fail = 0;
   logic [3:0] mflags = 4'b0000;

   always #4 clk = ~clk;

   flag_alu u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_i    (op),
      .a_i     (a),
      .b_i     (b),
      .res_o   (res),
      .wr_en_o (wr),
      .flags_o (flags)
   );

   // returns {wr, res[15:0], flags[3:0]}; flags packed {N,Z,C,V}
   function automatic logic [20:0] model(input logic [3:0] o, input logic [15:0] x,
                                         input logic [15:0] y, input logic [3:0] f);
      logic [15:0] r;
      logic        w, c, v, fc;
      logic [16:0] t;
      fc = f[1];
      r = '0; w = 1'b0; c = fc; v = f[0];
      case (o)
         4'd1, 4'd3: begin
            t = {1'b0, x} + {1'b0, y} + ((o == 4'd3) ? {16'd0, fc} : 17'd0);
            r = t[15:0]; c = t[16]; w = 1'b1;
            v = (x[15] == y[15]) && (r[15] != x[15]);
         end
         4'd2, 4'd4, 4'd5: begin
            t = {1'b0, y} + ((o == 4'd4) ? {16'd0, fc} : 17'd0);
            r = x - t[15:0];
            c = ({1'b0, x} < t);
            w = (o != 4'd5);
            v = (x[15] != y[15]) && (r[15] != x[15]);
         end
         4'd6: begin r = x | y; w = 1'b1; v = 1'b0; end
         4'd7: begin r = x & y; w = 1'b1; v = 1'b0; end
         4'd8: begin r = x ^ y; w = 1'b1; v = 1'b0; end
         4'd13: begin r = x & y; v = 1'b0; end
         4'd9:  begin r = x << 1; c = x[15]; w = 1'b1; v = r[15] ^ c; end
         4'd10: begin r = x >> 1; c = x[0]; w = 1'b1; v = r[15] ^ c; end
         4'd12: begin r = {x[15], x[15:1]}; c = x[0]; w = 1'b1; v = r[15] ^ c; end
         default: return {1'b0, 16'd0, f};
      endcase
      return {w, r, r[15], (r == 16'd0), c, v};
   endfunction

   function automatic string tag(input logic [3:0] o);
      case (o)
         4'd1: return "R2";
         4'd2: return "R3";
         4'd3, 4'd4: return "R4";
         4'd5, 4'd13: return "R5";
         4'd6, 4'd7, 4'd8: return "R6";
         4'd9: return "R7";
         4'd10, 4'd12: return "R8";
         default: return "R11";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input logic [3:0] o, input logic [15:0] x, input logic [15:0] y);
      logic [20:0] e;
      @(negedge clk);
      op = o; a = x; b = y;
      #1;
      e = model(o, x, y, mflags);
      check(res == e[19:4], tag(o), "result", {16'd0, res}, {16'd0, e[19:4]});
      check(wr == e[20], tag(o), "write enable", {31'd0, wr}, {31'd0, e[20]});
      // R12: flags must not move before the edge
      check(flags == mflags, "R12", "flags before edge", {28'd0, flags}, {28'd0, mflags});
      @(posedge clk);
      #1;
      // R10 N/Z, R9 shift V and per-op C/V together
      check(flags == e[3:0], (o == 4'd9 || o == 4'd10 || o == 4'd12) ? "R9" : "R10",
            {"flags after ", tag(o)}, {28'd0, flags}, {28'd0, e[3:0]});
      mflags = e[3:0];
   endtask

   initial begin
      #(8 * 190000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      check(flags == 4'b0000, "R1", "flags in reset", {28'd0, flags}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check(flags == 4'b0000, "R1", "flags after release", {28'd0, flags}, 32'd0);

      // directed corners
      run_op(4'd1, 16'hFFFF, 16'h0001);   // R2 wrap: Z,C
      run_op(4'd1, 16'h7FFF, 16'h0001);   // R2 overflow: N,V
      run_op(4'd2, 16'h0000, 16'h0001);   // R3 borrow
      run_op(4'd2, 16'h8000, 16'h0001);   // R3 overflow
      run_op(4'd1, 16'hFFFF, 16'hFFFF);   // carry set for next
      run_op(4'd3, 16'h0001, 16'h0002);   // R4 addc with C
      run_op(4'd2, 16'h0000, 16'h0001);   // set borrow
      run_op(4'd4, 16'h0005, 16'h0005);   // R4 subc borrows through C
      run_op(4'd4, 16'h0000, 16'hFFFF);   // R4 subc with C clear/set path
      run_op(4'd5, 16'h1234, 16'h1234);   // R5 cmp equal
      run_op(4'd13, 16'hF0F0, 16'h0F0F);  // R5 tst zero
      run_op(4'd2, 16'h0000, 16'h0001);   // C set
      run_op(4'd6, 16'h8000, 16'h0000);   // R6 C kept
      run_op(4'd8, 16'hAAAA, 16'hAAAA);   // R6 xor zero
      run_op(4'd9, 16'h8001, 16'h5555);   // R7 shl carry out
      run_op(4'd10, 16'h8001, 16'hFFFF);  // R8 lsr
      run_op(4'd12, 16'h8001, 16'h0000);  // R8 asr sign copy
      run_op(4'd12, 16'h4000, 16'h0000);  // R8 asr positive
      run_op(4'd1, 16'h7FFF, 16'h7FFF);   // nonzero flags
      run_op(4'd0, 16'h0000, 16'h0000);   // R11
      run_op(4'd11, 16'hFFFF, 16'h0001);  // R11
      run_op(4'd14, 16'h1234, 16'h4321);  // R11
      run_op(4'd15, 16'h8000, 16'h8000);  // R11

      for (int i = 0; i < 3000; i++) begin
         logic [3:0]  ro;
         logic [15:0] ra, rb;
         ro = 4'($urandom_range(0, 15));
         ra = 16'($urandom);
         rb = 16'($urandom);
         if (($urandom & 32'h7) == 0) ra = 16'hFFFF;
         if (($urandom & 32'h7) == 1) rb = ra;
         run_op(ro, ra, rb);
      end

      // R1: reset again with nonzero flags
      run_op(4'd2, 16'h0000, 16'h0001);
      @(negedge clk);
      op = 4'd0;
      rst_n = 1'b0;
      #1;
      check(flags == 4'b0000, "R1", "flags on async reset", {28'd0, flags}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      mflags = 4'b0000;
      run_op(4'd3, 16'h0001, 16'h0001);   // R4 addc with C cleared by reset

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule